// File: doc/BRIEF.md
# Coarse-Granularity Supervision Watchdog

This block supervises an application image after the device has handed control to it. Software programs a coarse timeout field that is only a few bits wide. The block widens that field into a full down-counter preset by appending a fixed low-order constant. The result is a timeout that can only be set in steps of 2^LO_W cycles, plus a small fixed offset. Counting stays off until the user-mode indication is first seen. After that the application has to pulse an active-low kick input periodically. If it does not, the counter reaches zero and the block issues a one-cycle timeout pulse. That pulse is the request to reload the factory image. At the same time the block sets a sticky watchdog status flag.

Counting is also gated by an enable bit from the control register. While that bit is low, the counter is held at its preset and no timeout can occur. Once the counter has expired it stays at zero. From then on it ignores kicks until the global reset, so a single expiry produces exactly one request. The clock is a slow internal oscillator whose frequency may lie anywhere between 5 and 10 MHz, so the real-time length of one step is only approximate.

Top module: `wdt_coarse_top`

## Requirements
- R1: While reset is held and right after it is released, timeout_o and wd_status_o are 0.
- R2: The preset equals {cfg_coarse, LO_FILL}: the coarse field forms the top HI_W bits and the constant LO_FILL forms the low LO_W bits. Before arming, count_o shows this preset.
- R3: Before user_mode is first seen high, count_o does not decrement. Arming is sticky: if user_mode later goes low, counting continues.
- R4: While armed, enabled and not kicked, count_o falls by exactly one per clock.
- R5: A clock edge with kick_n low, before expiry, loads count_o with the preset built from the current cfg_coarse.
- R6: timeout_o goes high for exactly one cycle, in the cycle in which count_o first reads 0. This is preset cycles after the arming edge or the last reload.
- R7: wd_status_o is set together with the timeout and stays high until reset.
- R8: After expiry, count_o holds 0, kicks are ignored and no further timeout pulse occurs.
- R9: A kick on the edge at which the count would reach 0 takes priority. The counter reloads and no timeout is issued.
- R10: While wd_en is low, count_o holds the preset and no timeout is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| wd_en | input | 1 | Watchdog enable bit from the control register |
| user_mode | input | 1 | High once the application image runs in user mode |
| kick_n | input | 1 | Active-low reload from the application |
| cfg_coarse | input | HI_W | Coarse timeout field |
| count_o | output | HI_W+LO_W | Current counter value |
| timeout_o | output | 1 | One-cycle expiry pulse; request to load the factory image |
| wd_status_o | output | 1 | Sticky watchdog-expired status |

## Verification
A kick and the final decrement can fall on the same clock edge. That is the collision this block must resolve. The bench provokes it by polling count_o at each falling edge until it reads 1 and then driving kick_n low for the next rising edge. It then judges that count_o shows the full preset again, that timeout_o stayed low and that the status flag is still clear. A later undisturbed run from that reload must produce exactly one pulse, at the predicted cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } wdt_phase_e;
endpackage

// File: rtl/wdt_phase.sv
module wdt_phase
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       user_mode,
  input  logic       expire_evt,
  output wdt_phase_e phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_WAIT;
    end else begin
      unique case (phase)
        PH_WAIT: if (user_mode) phase <= PH_RUN;
        PH_RUN:  if (expire_evt) phase <= PH_DONE;
        default: phase <= PH_DONE;
      endcase
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdt_phase_e       phase,
  input  logic             wd_en,
  input  logic             kick_n,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count,
  output logic             expire_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic ticking;
  assign ticking    = (phase == PH_RUN) && wd_en && kick_n;
  assign expire_evt = ticking && (count <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else begin
      unique case (phase)
        PH_WAIT: count <= preset;
        PH_RUN: begin
          if (!wd_en || !kick_n) count <= preset;
          else if (count > ONE)  count <= count - ONE;
          else                   count <= '0;
        end
        default: count <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_flags.sv
module wdt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_evt,
  output logic timeout,
  output logic status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout <= 1'b0;
      status  <= 1'b0;
    end else begin
      timeout <= expire_evt;
      status  <= status | expire_evt;
    end
  end
endmodule

// File: rtl/wdt_coarse_top.sv
module wdt_coarse_top
  import wdt_pkg::*;
#(
  parameter int HI_W    = 12,
  parameter int LO_W    = 17,
  parameter int LO_FILL = 8,
  localparam int CNT_W  = HI_W + LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_en,
  input  logic             user_mode,
  input  logic             kick_n,
  input  logic [HI_W-1:0]  cfg_coarse,
  output logic [CNT_W-1:0] count_o,
  output logic             timeout_o,
  output logic             wd_status_o
);
  localparam logic [LO_W-1:0] LOW_CONST = LO_W'(LO_FILL);

  logic [CNT_W-1:0] preset;
  logic             expire_evt;
  wdt_phase_e       phase;

  assign preset = {cfg_coarse, LOW_CONST};

  wdt_phase u_phase (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
    .expire_evt(expire_evt), .phase(phase)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .phase(phase), .wd_en(wd_en),
    .kick_n(kick_n), .preset(preset), .count(count_o),
    .expire_evt(expire_evt)
  );

  wdt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .expire_evt(expire_evt),
    .timeout(timeout_o), .status(wd_status_o)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int HI_W    = 12,
  parameter int LO_W    = 17,
  parameter int LO_FILL = 8,
  localparam int CNT_W  = HI_W + LO_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wd_en,
  input logic             kick_n,
  input logic [HI_W-1:0]  cfg_coarse,
  input logic [CNT_W-1:0] count_o,
  input logic             timeout_o,
  input logic             wd_status_o
);
  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
  // R6
  pulse_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (count_o == '0) && wd_status_o);
  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_status_o |=> wd_status_o);
  // R8
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_status_o |-> (count_o == '0));
  // R9
  kick_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !kick_n |=> !timeout_o);
  // R5
  kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick_n && !wd_status_o) |=>
      (count_o == {$past(cfg_coarse), LO_W'(LO_FILL)}));
  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> !timeout_o);
endmodule

bind wdt_coarse_top wdt_chk #(.HI_W(HI_W), .LO_W(LO_W), .LO_FILL(LO_FILL)) u_chk (
  .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .kick_n(kick_n),
  .cfg_coarse(cfg_coarse), .count_o(count_o), .timeout_o(timeout_o),
  .wd_status_o(wd_status_o)
);

// File: tb/sim_wdt_coarse_top.sv
module sim_wdt_coarse_top;
  localparam int CLK_PERIOD = 10;
  localparam int HI_W = 12;
  localparam int LO_W = 5;
  localparam int LO_FILL = 8;
  localparam int CNT_W = HI_W + LO_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wd_en = 1'b1;
  logic user_mode = 1'b0;
  logic kick_n = 1'b1;
  logic [HI_W-1:0] cfg_coarse = '0;
  logic [CNT_W-1:0] count_o;
  logic timeout_o, wd_status_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_coarse_top #(.HI_W(HI_W), .LO_W(LO_W), .LO_FILL(LO_FILL)) u0 (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .user_mode(user_mode),
    .kick_n(kick_n), .cfg_coarse(cfg_coarse), .count_o(count_o),
    .timeout_o(timeout_o), .wd_status_o(wd_status_o)
  );

  function automatic int preset_of(int c);
    return c * (1 << LO_W) + LO_FILL;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: pops expected timeout cycles
  always @(negedge clk) begin
    if (rst_n && timeout_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 R8 R9 R10: unexpected timeout at cycle %0d expected none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc) begin
          errors++;
          $display("FAIL R6: timeout at cycle %0d expected %0d", cyc, e);
        end
      end
    end
  end

  initial begin
    int prev;
    tick(3);
    check("R1 timeout in reset", timeout_o, 0);
    check("R1 status in reset", wd_status_o, 0);
    rst_n = 1'b1;
    cfg_coarse = 12'd2;
    tick(1);
    check("R1 timeout after release", timeout_o, 0);
    check("R1 status after release", wd_status_o, 0);
    tick(3);
    check("R2 preset shown", count_o, preset_of(2));
    tick(4);
    check("R3 no count before user mode", count_o, preset_of(2));
    user_mode = 1'b1;
    tick(1);
    check("R3 armed load", count_o, preset_of(2));
    tick(1);
    check("R4 first decrement", count_o, preset_of(2) - 1);
    user_mode = 1'b0;
    prev = count_o;
    tick(10);
    check("R3 R4 sticky arming, ten steps", count_o, prev - 10);
    cfg_coarse = 12'd1;
    kick_n = 1'b0;
    tick(1);
    kick_n = 1'b1;
    check("R5 kick reload new cfg", count_o, preset_of(1));
    tick(1);
    check("R4 after reload", count_o, preset_of(1) - 1);
    wd_en = 1'b0;
    tick(1);
    check("R10 disabled reload", count_o, preset_of(1));
    tick(100);
    check("R10 disabled hold", count_o, preset_of(1));
    check("R10 disabled no status", wd_status_o, 0);
    wd_en = 1'b1;
    while (count_o != 1) tick(1);
    kick_n = 1'b0;
    tick(1);
    check("R9 kick at last step reloads", count_o, preset_of(1));
    check("R9 no timeout", timeout_o, 0);
    check("R9 no status", wd_status_o, 0);
    kick_n = 1'b1;
    exp_q.push_back(cyc + preset_of(1));
    tick(preset_of(1));
    check("R6 pulse at zero", timeout_o, 1);
    check("R6 count zero", count_o, 0);
    check("R7 status set", wd_status_o, 1);
    tick(1);
    check("R6 pulse one cycle", timeout_o, 0);
    kick_n = 1'b0;
    tick(3);
    kick_n = 1'b1;
    check("R8 kick ignored after expiry", count_o, 0);
    wd_en = 1'b0;
    tick(20);
    wd_en = 1'b1;
    tick(10);
    check("R8 holds zero", count_o, 0);
    check("R7 status sticky", wd_status_o, 1);
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    check("R7 reset clears status", wd_status_o, 0);
    cfg_coarse = 12'd0;
    user_mode = 1'b1;
    exp_q.push_back(cyc + preset_of(0) + 1);
    tick(preset_of(0) + 1);
    check("R6 minimum preset timeout", timeout_o, 1);
    tick(12);
    check("R7 status after second expiry", wd_status_o, 1);
    check("R6 scoreboard drained", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule